// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that counts pulses from a slow free-running oscillator, delivered to it as single-cycle ticks already synchronised to the system clock. A prescaler divides the ticks by 32 or by 128, selected by one configuration bit. A postscaler then divides the prescaler output by a power of two from 1 to 32768, selected by a 4-bit code. When the combined count runs out, the block raises a one-cycle reset request. If the core is asleep or idle at that point, it raises a one-cycle wake-up request instead. Either way it sets a sticky time-out flag that software must clear.

Software restarts the count with a clear pulse. Entering or leaving a low-power mode restarts it too, and so does a finished clock switch or a device reset. When window mode is active, software may clear only in the final quarter of the period. A clear that comes earlier is taken as a runaway program and produces an immediate reset request.

The watchdog runs when either of two bits is set: the always-on configuration bit, or a software enable bit held in the block. A device reset clears the software enable bit. All controls here are plain level or pulse pins. There is no streaming data path, so no valid/ready handshake applies.

Top module: `wdog_win`

## Requirements
- R1: While and right after the device reset (rst_ni low), rst_req_o, wake_o and flag_o read 0, and the software enable bit reads 0.
- R2: With the watchdog enabled and no restart, the period is P × 2^code ticks, where P is the prescaler ratio. The tick that completes the period makes rst_req_o high for exactly one clock, in the cycle after that tick. It also sets flag_o and restarts the count from zero.
- R3: cfg_pre_sel_i = 0 gives P = 32 and cfg_pre_sel_i = 1 gives P = 128. cfg_post_code_i = n gives a postscaler ratio of 2^n, for n from 0 to 15.
- R4: Any of the following returns the count to zero: a clear pulse (clr_i), sleep entry (sleep_enter_i), sleep exit (sleep_exit_i), a finished clock switch (clk_switch_done_i), or a device reset. A full period is counted afresh from the next tick.
- R5: The watchdog is enabled when cfg_always_on_i = 1, or when the software enable bit is 1. A cycle with sw_en_we_i = 1 loads sw_en_wd_i into the software enable bit. A device reset clears that bit.
- R6: While disabled, the count is held at zero. Ticks and clears then produce no reset request and no wake-up request.
- R7: Sleep entry puts the block into low-power state and sleep exit takes it out; if both arrive in one cycle, entry wins. A time-out in low-power state makes wake_o high for one clock instead of rst_req_o, and still sets flag_o.
- R8: flag_o stays 1 until a flag_clr_i pulse clears it. If a time-out and flag_clr_i occur in the same cycle, flag_o is set.
- R9: With cfg_win_dis_i = 0 and the watchdog enabled, a clear arriving while the tick count is below 3/4 of the period makes rst_req_o high in the next cycle. flag_o is not changed.
- R10: A clear arriving when the count is at or above 3/4 of the period, or at any count when cfg_win_dis_i = 1, only restarts the count and produces no request.
- R11: A restart event in the same cycle as a tick takes priority: that tick is not counted and cannot complete a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Device reset, active low, asynchronous |
| tick_i | input | 1 | One-cycle pulse per slow oscillator period |
| cfg_pre_sel_i | input | 1 | Prescaler select: 0 divides by 32, 1 divides by 128 |
| cfg_post_code_i | input | 4 | Postscaler code n, ratio 2^n |
| cfg_always_on_i | input | 1 | Watchdog runs regardless of software |
| cfg_win_dis_i | input | 1 | 1 turns window checking off |
| sw_en_we_i | input | 1 | Write strobe for the software enable bit |
| sw_en_wd_i | input | 1 | Value written to the software enable bit |
| clr_i | input | 1 | Software clear pulse |
| sleep_enter_i | input | 1 | Pulse on entry into sleep or idle |
| sleep_exit_i | input | 1 | Pulse on exit from sleep or idle |
| clk_switch_done_i | input | 1 | Pulse when a clock switch completes |
| flag_clr_i | input | 1 | Software clear of the time-out flag |
| rst_req_o | output | 1 | One-cycle reset request |
| wake_o | output | 1 | One-cycle wake-up request |
| flag_o | output | 1 | Sticky time-out flag |

## Verification
Each result is registered, so it becomes due exactly one clock after the cycle in which the causing input was presented. This holds for a reset request, a wake-up request and a flag change, whether the cause is the completing tick, an early clear or a flag clear. The bench drives inputs just after a falling edge and advances its own model by one step for that cycle. It compares the outputs at the next falling edge, which is the first point after the capturing rising edge. The directed checks count ticks to the edge of the period and to the edge of the window, so a single extra or missing tick shows up as a request in the wrong cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int WDOG_CODE_W = 4;

  typedef struct packed {
    logic                   pre_sel;
    logic [WDOG_CODE_W-1:0] post_code;
    logic                   always_on;
    logic                   win_dis;
  } wdog_cfg_t;

  typedef struct packed {
    logic clr;
    logic sleep_enter;
    logic sleep_exit;
    logic clk_switch;
  } wdog_evt_t;

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int LO_LOG2 = 5,
  parameter int HI_LOG2 = 7,
  localparam int W = HI_LOG2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         tick_i,
  input  logic         sel_i,
  output logic [W-1:0] cnt_o,
  output logic         carry_o
);

  localparam logic [W-1:0] LAST_LO = W'((1 << LO_LOG2) - 1);
  localparam logic [W-1:0] LAST_HI = W'((1 << HI_LOG2) - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] last;

  assign last    = sel_i ? LAST_HI : LAST_LO;
  assign carry_o = tick_i && !clear_i && (cnt_q >= last);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= carry_o ? '0 : cnt_q + 1'b1;
    end
  end

  // R11: a restart always leaves the prescaler at zero, even with a tick present
  a_r11_pre_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));

endmodule

// File: rtl/wdog_postscale.sv
module wdog_postscale #(
  parameter int MAX_LOG2 = 15,
  parameter int CODE_W   = 4,
  localparam int W = MAX_LOG2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [W-1:0]      cnt_o,
  output logic              term_o
);

  logic [W-1:0] cnt_q;
  logic [W:0]   ratio;
  logic [W-1:0] last;

  assign ratio  = (W+1)'(1) << code_i;
  assign last   = W'(ratio - 1'b1);
  assign term_o = step_i && !clear_i && (cnt_q >= last);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= term_o ? '0 : cnt_q + 1'b1;
    end
  end

  // R2: the postscaler moves only on a prescaler carry or a restart
  a_r2_post_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clear_i) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int LO_LOG2  = 5,
  parameter int HI_LOG2  = 7,
  parameter int MAX_LOG2 = 15,
  parameter int CODE_W   = 4,
  localparam int CW = HI_LOG2 + MAX_LOG2
) (
  input  logic                pre_sel_i,
  input  logic [CODE_W-1:0]   code_i,
  input  logic [HI_LOG2-1:0]  pre_cnt_i,
  input  logic [MAX_LOG2-1:0] post_cnt_i,
  output logic                open_o
);

  logic [CW-1:0] combined;
  logic [CW-1:0] thresh;
  int unsigned   sh;

  always_comb begin
    if (pre_sel_i) begin
      combined = (CW'(post_cnt_i) << HI_LOG2) | CW'(pre_cnt_i);
      sh       = HI_LOG2 + int'(code_i) - 2;
    end else begin
      combined = (CW'(post_cnt_i) << LO_LOG2) | CW'(pre_cnt_i);
      sh       = LO_LOG2 + int'(code_i) - 2;
    end
    thresh = CW'(3) << sh;
    open_o = (combined >= thresh);
  end

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  wdog_cfg_t cfg_i,
  input  wdog_evt_t evt_i,
  input  logic      sw_en_we_i,
  input  logic      sw_en_wd_i,
  input  logic      flag_clr_i,
  input  logic      term_i,
  input  logic      window_open_i,
  output logic      cnt_clear_o,
  output logic      rst_req_o,
  output logic      wake_o,
  output logic      flag_o
);

  logic sw_en_q, in_sleep_q, rst_req_q, wake_q, flag_q;
  logic enabled, restart, timeout, early;

  assign enabled     = cfg_i.always_on || sw_en_q;
  assign restart     = evt_i.clr || evt_i.sleep_enter || evt_i.sleep_exit || evt_i.clk_switch;
  assign cnt_clear_o = !enabled || restart;
  assign timeout     = enabled && !restart && term_i;
  assign early       = enabled && evt_i.clr && !cfg_i.win_dis && !window_open_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_en_q    <= 1'b0;
      in_sleep_q <= 1'b0;
      rst_req_q  <= 1'b0;
      wake_q     <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      if (sw_en_we_i) sw_en_q <= sw_en_wd_i;
      if (evt_i.sleep_enter)     in_sleep_q <= 1'b1;
      else if (evt_i.sleep_exit) in_sleep_q <= 1'b0;
      rst_req_q <= early || (timeout && !in_sleep_q);
      wake_q    <= timeout && in_sleep_q;
      if (timeout)         flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign rst_req_o = rst_req_q;
  assign wake_o    = wake_q;
  assign flag_o    = flag_q;

  // R7: a time-out never asks for both a wake-up and a reset
  a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_q |-> !wake_q);

  // R7: every wake-up comes from a time-out, which also marks the flag
  a_r7_wake_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_q |-> flag_q);

  // R8: the flag holds until software clears it
  a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !flag_clr_i) |=> flag_q);

  // R6: a disabled watchdog raises no request
  a_r6_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enabled |=> (!rst_req_q && !wake_q));

endmodule

// File: rtl/wdog_win.sv
module wdog_win
  import wdog_pkg::*;
#(
  parameter int PRE_LO_LOG2 = 5,
  parameter int PRE_HI_LOG2 = 7,
  localparam int POST_MAX_LOG2 = (1 << WDOG_CODE_W) - 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic                   cfg_pre_sel_i,
  input  logic [WDOG_CODE_W-1:0] cfg_post_code_i,
  input  logic                   cfg_always_on_i,
  input  logic                   cfg_win_dis_i,
  input  logic                   sw_en_we_i,
  input  logic                   sw_en_wd_i,
  input  logic                   clr_i,
  input  logic                   sleep_enter_i,
  input  logic                   sleep_exit_i,
  input  logic                   clk_switch_done_i,
  input  logic                   flag_clr_i,
  output logic                   rst_req_o,
  output logic                   wake_o,
  output logic                   flag_o
);

  wdog_cfg_t cfg;
  wdog_evt_t evt;

  logic [PRE_HI_LOG2-1:0]   pre_cnt;
  logic [POST_MAX_LOG2-1:0] post_cnt;
  logic pre_carry, post_term, win_open, cnt_clear;

  assign cfg = '{pre_sel:   cfg_pre_sel_i,
                 post_code: cfg_post_code_i,
                 always_on: cfg_always_on_i,
                 win_dis:   cfg_win_dis_i};
  assign evt = '{clr:         clr_i,
                 sleep_enter: sleep_enter_i,
                 sleep_exit:  sleep_exit_i,
                 clk_switch:  clk_switch_done_i};

  wdog_prescale #(.LO_LOG2(PRE_LO_LOG2), .HI_LOG2(PRE_HI_LOG2)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (cnt_clear),
    .tick_i  (tick_i),
    .sel_i   (cfg.pre_sel),
    .cnt_o   (pre_cnt),
    .carry_o (pre_carry)
  );

  wdog_postscale #(.MAX_LOG2(POST_MAX_LOG2), .CODE_W(WDOG_CODE_W)) u_post (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (cnt_clear),
    .step_i  (pre_carry),
    .code_i  (cfg.post_code),
    .cnt_o   (post_cnt),
    .term_o  (post_term)
  );

  wdog_window #(.LO_LOG2(PRE_LO_LOG2), .HI_LOG2(PRE_HI_LOG2),
                .MAX_LOG2(POST_MAX_LOG2), .CODE_W(WDOG_CODE_W)) u_win (
    .pre_sel_i  (cfg.pre_sel),
    .code_i     (cfg.post_code),
    .pre_cnt_i  (pre_cnt),
    .post_cnt_i (post_cnt),
    .open_o     (win_open)
  );

  wdog_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_i         (cfg),
    .evt_i         (evt),
    .sw_en_we_i    (sw_en_we_i),
    .sw_en_wd_i    (sw_en_wd_i),
    .flag_clr_i    (flag_clr_i),
    .term_i        (post_term),
    .window_open_i (win_open),
    .cnt_clear_o   (cnt_clear),
    .rst_req_o     (rst_req_o),
    .wake_o        (wake_o),
    .flag_o        (flag_o)
  );

endmodule

// File: tb/wdog_win_test.sv
`timescale 1ns/1ps
module wdog_win_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, pre_sel = 0, always_on = 0, win_dis = 0;
  logic [3:0] code = 0;
  logic we = 0, wd = 0, clr = 0, s_in = 0, s_out = 0, csw = 0, fclr = 0;
  logic rst_req, wake, flag;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model state
  longint m_cnt;
  bit m_sleep, m_swen, m_flag, e_rst, e_wake;

  always #4 clk = ~clk;

  wdog_win uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .cfg_pre_sel_i(pre_sel), .cfg_post_code_i(code),
    .cfg_always_on_i(always_on), .cfg_win_dis_i(win_dis),
    .sw_en_we_i(we), .sw_en_wd_i(wd), .clr_i(clr),
    .sleep_enter_i(s_in), .sleep_exit_i(s_out),
    .clk_switch_done_i(csw), .flag_clr_i(fclr),
    .rst_req_o(rst_req), .wake_o(wake), .flag_o(flag)
  );

  function automatic longint period();
    return longint'(1) << ((pre_sel ? 7 : 5) + int'(code));
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_sleep = 0; m_swen = 0; m_flag = 0; e_rst = 0; e_wake = 0;
  endtask

  task automatic model_step();
    bit en, rs, to;
    longint tot;
    en = always_on || m_swen;
    rs = clr || s_in || s_out || csw;
    tot = period();
    e_rst = 0; e_wake = 0; to = 0;
    if (!en) m_cnt = 0;
    else if (rs) begin
      if (clr && !win_dis && (m_cnt * 4 < tot * 3)) e_rst = 1;
      m_cnt = 0;
    end else if (tick) begin
      if (m_cnt >= tot - 1) begin to = 1; m_cnt = 0; end
      else m_cnt++;
    end
    if (to) begin
      if (m_sleep) e_wake = 1; else e_rst = 1;
    end
    if (to) m_flag = 1; else if (fclr) m_flag = 0;
    if (s_in) m_sleep = 1; else if (s_out) m_sleep = 0;
    if (we) m_swen = wd;
  endtask

  // one clock: inputs are presented now, results compared one edge later
  task automatic cyc(bit t, bit c = 0, bit si = 0, bit so = 0, bit cs = 0,
                     bit fc = 0, bit w = 0, bit d = 0);
    tick = t; clr = c; s_in = si; s_out = so; csw = cs; fclr = fc; we = w; wd = d;
    model_step();
    @(negedge clk);
    chk("R2 model rst_req", rst_req, e_rst);
    chk("R7 model wake", wake, e_wake);
    chk("R8 model flag", flag, m_flag);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(1);
  endtask

  task automatic dev_reset();
    tick = 0; clr = 0; s_in = 0; s_out = 0; csw = 0; fclr = 0; we = 0; wd = 0;
    rst_n = 0;
    model_reset();
    @(negedge clk);
    chk("R1 rst_req in reset", rst_req, 1'b0);
    chk("R1 flag in reset", flag, 1'b0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 wake after reset", wake, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit seen;
    void'($urandom(32'd20240611));
    @(negedge clk);
    pre_sel = 0; code = 0; always_on = 0; win_dis = 0;
    dev_reset();

    // R5, R6: not always on and software enable cleared by reset -> never fires
    seen = 0;
    for (int i = 0; i < 80; i++) begin cyc(1); seen |= rst_req; end
    cyc(1, 1);
    seen |= rst_req;
    chk("R5 disabled after reset", seen, 1'b0);
    chk("R6 clear while disabled", rst_req, 1'b0);

    // R5: software enable on -> 32-tick period
    cyc(0, 0, 0, 0, 0, 0, 1, 1);
    ticks(31);
    chk("R5 sw enable before end", rst_req, 1'b0);
    cyc(1);
    chk("R5 sw enable time-out", rst_req, 1'b1);
    // R5: software enable off again
    cyc(0, 0, 0, 0, 0, 1, 1, 0);
    seen = 0;
    for (int i = 0; i < 70; i++) begin cyc(1); seen |= rst_req | wake; end
    chk("R6 sw disabled quiet", seen, 1'b0);
    // R5: device reset clears the software enable bit
    cyc(0, 0, 0, 0, 0, 0, 1, 1);
    dev_reset();
    seen = 0;
    for (int i = 0; i < 40; i++) begin cyc(1); seen |= rst_req; end
    chk("R5 reset clears sw enable", seen, 1'b0);

    // R2, R3: always on, divide by 32, ratio 1
    always_on = 1;
    dev_reset();
    ticks(31);
    chk("R2 no request at 31 ticks", rst_req, 1'b0);
    cyc(1);
    chk("R2 request at 32 ticks", rst_req, 1'b1);
    chk("R2 flag set", flag, 1'b1);
    cyc(0);
    chk("R2 request one cycle", rst_req, 1'b0);
    // R8: flag sticky, then cleared
    cyc(0);
    chk("R8 flag held", flag, 1'b1);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R8 flag cleared", flag, 1'b0);

    // R3: divide by 128, code 0
    pre_sel = 1;
    dev_reset();
    ticks(127);
    chk("R3 no request at 127", rst_req, 1'b0);
    cyc(1);
    chk("R3 request at 128", rst_req, 1'b1);
    // R3: divide by 32, code 2 -> 128 ticks
    pre_sel = 0; code = 2;
    dev_reset();
    ticks(127);
    chk("R3 code 2 none at 127", rst_req, 1'b0);
    cyc(1, 0, 0, 0, 0, 1);
    chk("R3 code 2 request at 128", rst_req, 1'b1);
    chk("R8 set wins over clear", flag, 1'b1);

    // R9, R10: window at 24 of 32
    code = 0;
    dev_reset();
    ticks(23);
    cyc(0, 1);
    chk("R9 early clear resets", rst_req, 1'b1);
    chk("R9 flag untouched", flag, 1'b0);
    ticks(24);
    cyc(0, 1);
    chk("R10 clear in window", rst_req, 1'b0);
    // R4: clear restarted the count
    ticks(31);
    chk("R4 restart after clear", rst_req, 1'b0);
    cyc(1);
    chk("R4 full period after clear", rst_req, 1'b1);
    // R10: window disabled
    win_dis = 1;
    cyc(1);
    cyc(0, 1);
    chk("R10 window off early clear", rst_req, 1'b0);
    win_dis = 0;

    // R11: clear coincident with the completing tick
    ticks(31);
    cyc(1, 1);
    chk("R11 restart beats tick", rst_req, 1'b0);
    ticks(31);
    chk("R11 counted afresh", rst_req, 1'b0);
    cyc(1);
    chk("R11 period after restart", rst_req, 1'b1);

    // R7: sleep entry restarts, time-out wakes
    cyc(0, 0, 0, 0, 0, 1);
    cyc(1, 0, 1);
    ticks(31);
    chk("R4 sleep entry restarts", wake, 1'b0);
    cyc(1);
    chk("R7 wake in sleep", wake, 1'b1);
    chk("R7 no reset in sleep", rst_req, 1'b0);
    chk("R7 flag on wake", flag, 1'b1);
    // R4: sleep exit and clock switch restart
    ticks(10);
    cyc(0, 0, 0, 1);
    ticks(20);
    cyc(0, 0, 0, 0, 1);
    ticks(31);
    chk("R4 clock switch restarts", rst_req, 1'b0);
    cyc(1);
    chk("R7 reset after exit", rst_req, 1'b1);

    // random phases compared against the model
    for (int ph = 0; ph < 10; ph++) begin
      pre_sel   = 1'($urandom_range(0, 1));
      code      = 4'($urandom_range(0, pre_sel ? 2 : 4));
      always_on = 1'($urandom_range(0, 1));
      win_dis   = 1'($urandom_range(0, 1));
      dev_reset();
      if (!always_on) cyc(0, 0, 0, 0, 0, 0, 1, 1);
      for (int i = 0; i < 3500; i++) begin
        cyc(bit'($urandom_range(0, 1)),
            $urandom_range(0, 1499) == 0,
            $urandom_range(0, 1199) == 0,
            $urandom_range(0, 899) == 0,
            $urandom_range(0, 1999) == 0,
            $urandom_range(0, 299) == 0,
            $urandom_range(0, 2499) == 0,
            $urandom_range(0, 3) != 0);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule